// File: doc/BRIEF.md
# Windowed Instruction Register File

This block keeps a small store of frequently executed instruction words that a fetch stage can reach through a 5-bit index instead of a full memory access. The store is divided into several windows, each with 32 slots, and only one window is visible at a time. A window pointer selects the visible window. Program code changes the pointer by calling a function: the top bits of the call target name the window that function uses.

A call produces a cleaned program-counter value with the window bits cleared. It also produces a link word that holds the return address, with the window that was active at the call placed in its top bits. A return takes a link word, makes active the window recorded there, and produces the cleaned return address. Windows are therefore not switched in stack order: any call or return can move to any window. The lowest SHARED slots are common to every window and are held once. Slot 0 always reads as the no-op word. A load port writes instruction words into any slot of any window, whatever window is active.

Top module: `irf_windowed`

## Requirements
- R1: While reset is held and just after it, `active_win` is 0 and every read index returns the no-op word (all zeros).
- R2: When `call_valid` is high, `call_pc` equals `call_target` with its two most significant bits cleared, in the same cycle. From the next cycle, `active_win` equals `call_target[31:30]`.
- R3: When `call_valid` is high, `call_link` equals `call_ret_addr[29:0]` with the window active in that cycle placed in bits 31:30.
- R4: `ret_pc` equals `ret_link` with bits 31:30 cleared. When `ret_valid` is high and `call_valid` is low, `active_win` equals `ret_link[31:30]` from the next cycle, whatever the earlier window history.
- R5: When a call and a return are presented in the same cycle, the call decides the next window.
- R6: Read index 0 returns the no-op word in every window. A load to index 0 has no effect.
- R7: Indices 1 to SHARED-1 (SHARED = 4 by default) read one common store. A load to such an index is seen from every window, whatever `ld_win` carries, and a window switch does not change what these indices read.
- R8: Indices SHARED to 31 read the slots of the active window only. A load to another window leaves every read of the active window unchanged.
- R9: A loaded word is returned by a read of the same window and index from the cycle after the load.
- R10: With neither a call nor a return, `active_win` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_idx | input | 5 | Read index into the active window |
| rd_inst | output | 32 | Instruction word at `rd_idx` (combinational) |
| ld_valid | input | 1 | Load strobe |
| ld_win | input | 2 | Window that the load targets (ignored for shared indices) |
| ld_idx | input | 5 | Slot that the load targets |
| ld_data | input | 32 | Instruction word to store |
| call_valid | input | 1 | Call event this cycle |
| call_target | input | 32 | Call target; bits 31:30 carry the new window |
| call_ret_addr | input | 32 | Return address of the call |
| call_pc | output | 32 | Call target with the window bits cleared |
| call_link | output | 32 | Link word: return address tagged with the current window |
| ret_valid | input | 1 | Return event this cycle |
| ret_link | input | 32 | Saved link word of the return |
| ret_pc | output | 32 | Return address with the window bits cleared |
| active_win | output | 2 | Window pointer currently in effect |

## Verification
The bench builds the block with four windows of 32 slots and four shared slots, so both pointer bits take all four values and the shared boundary falls between indices 3 and 4, where reads flip from the common store to the per-window store. With four windows a return can land on a window other than the one before the latest call, which exercises the non-stack restore. Loads aimed at windows other than the active one happen in most cycles of the random phase, so a load that leaks into the visible window shows up in the per-cycle read comparison.

// File: rtl/irf_pkg.sv
package irf_pkg;

  // Pointer event taken at a clock edge
  typedef enum logic [1:0] {
    EVT_HOLD = 2'd0,
    EVT_CALL = 2'd1,
    EVT_RET  = 2'd2
  } irf_evt_e;

  // Word returned for slot 0 and for every slot after reset
  localparam logic [31:0] IRF_NOP_WORD = 32'h0000_0000;

endpackage

// File: rtl/irf_win_ptr.sv
module irf_win_ptr #(
  parameter int ADDR_W = 32,
  parameter int WPTR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_valid,
  input  logic [ADDR_W-1:0] call_target,
  input  logic              ret_valid,
  input  logic [ADDR_W-1:0] ret_link,
  output logic [WPTR_W-1:0] wptr,
  output irf_pkg::irf_evt_e evt
);
  import irf_pkg::*;

  // Window field lives in the top bits of an address or link word
  function automatic logic [WPTR_W-1:0] win_field(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: WPTR_W];
  endfunction

  logic [WPTR_W-1:0] wptr_q;
  logic [WPTR_W-1:0] wptr_d;

  // A call outranks a return in the same cycle
  always_comb begin
    if (call_valid)     evt = EVT_CALL;
    else if (ret_valid) evt = EVT_RET;
    else                evt = EVT_HOLD;
  end

  always_comb begin
    unique case (evt)
      EVT_CALL: wptr_d = win_field(call_target);
      EVT_RET:  wptr_d = win_field(ret_link);
      default:  wptr_d = wptr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wptr_q <= '0;
    else        wptr_q <= wptr_d;
  end

  assign wptr = wptr_q;

endmodule

// File: rtl/irf_addr_xlate.sv
module irf_addr_xlate #(
  parameter int ADDR_W = 32,
  parameter int WPTR_W = 2
) (
  input  logic [WPTR_W-1:0] wptr,
  input  logic [ADDR_W-1:0] call_target,
  input  logic [ADDR_W-1:0] call_ret_addr,
  input  logic [ADDR_W-1:0] ret_link,
  output logic [ADDR_W-1:0] call_pc,
  output logic [ADDR_W-1:0] call_link,
  output logic [ADDR_W-1:0] ret_pc
);
  localparam int PC_W = ADDR_W - WPTR_W;

  // Remove the window field, leaving a plain fetch address
  function automatic logic [ADDR_W-1:0] strip_win(input logic [ADDR_W-1:0] a);
    return {{WPTR_W{1'b0}}, a[PC_W-1:0]};
  endfunction

  // Place a window number above the address bits of a return address
  function automatic logic [ADDR_W-1:0] tag_win(input logic [ADDR_W-1:0] a,
                                                input logic [WPTR_W-1:0] w);
    return {w, a[PC_W-1:0]};
  endfunction

  assign call_pc   = strip_win(call_target);
  assign call_link = tag_win(call_ret_addr, wptr);
  assign ret_pc    = strip_win(ret_link);

endmodule

// File: rtl/irf_bank_store.sv
module irf_bank_store #(
  parameter int NUM_WIN = 4,
  parameter int ENTRIES = 32,
  parameter int SHARED  = 4,
  parameter int INST_W  = 32,
  parameter logic [INST_W-1:0] NOP = '0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(ENTRIES)-1:0] rd_idx,
  input  logic [$clog2(NUM_WIN)-1:0] rd_win,
  output logic [INST_W-1:0]          rd_inst,
  input  logic                       ld_valid,
  input  logic [$clog2(NUM_WIN)-1:0] ld_win,
  input  logic [$clog2(ENTRIES)-1:0] ld_idx,
  input  logic [INST_W-1:0]          ld_data
);
  localparam int IDX_W     = $clog2(ENTRIES);
  localparam int WPTR_W    = $clog2(NUM_WIN);
  localparam int WIN_DEPTH = ENTRIES - SHARED;
  localparam logic [IDX_W-1:0] SH_LIM = IDX_W'(SHARED);

  // Position of a private slot inside a window's own array
  function automatic logic [IDX_W-1:0] win_slot(input logic [IDX_W-1:0] idx);
    return idx - SH_LIM;
  endfunction

  // Decoded load targets and read class
  logic                 ld_shared_hit;
  logic [NUM_WIN-1:0]   ld_win_hit;
  logic                 rd_is_nop;
  logic                 rd_is_shared;
  logic [INST_W-1:0]    shared_rd;
  logic [INST_W-1:0]    win_rd [NUM_WIN];

  assign ld_shared_hit = ld_valid && (ld_idx != '0) && (ld_idx < SH_LIM);
  assign rd_is_nop     = (rd_idx == '0);
  assign rd_is_shared  = (rd_idx < SH_LIM);

  // Common slots, stored once (slot 0 is never written)
  logic [INST_W-1:0] shared_q [SHARED];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SHARED; i++) shared_q[i] <= NOP;
    end else if (ld_shared_hit) begin
      shared_q[ld_idx[$clog2(SHARED > 1 ? SHARED : 2)-1:0]] <= ld_data;
    end
  end

  assign shared_rd = shared_q[rd_idx[$clog2(SHARED > 1 ? SHARED : 2)-1:0]];

  // Private slots, one array per window
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [INST_W-1:0] slot_q [WIN_DEPTH];

    assign ld_win_hit[w] = ld_valid && (ld_idx >= SH_LIM) &&
                           (ld_win == WPTR_W'(w));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < WIN_DEPTH; i++) slot_q[i] <= NOP;
      end else if (ld_win_hit[w]) begin
        slot_q[win_slot(ld_idx)] <= ld_data;
      end
    end

    assign win_rd[w] = rd_is_shared ? NOP : slot_q[win_slot(rd_idx)];
  end

  always_comb begin
    if (rd_is_nop)         rd_inst = NOP;
    else if (rd_is_shared) rd_inst = shared_rd;
    else                   rd_inst = win_rd[rd_win];
  end

endmodule

// File: rtl/irf_windowed.sv
module irf_windowed #(
  parameter int NUM_WIN = 4,
  parameter int ENTRIES = 32,
  parameter int SHARED  = 4,
  parameter int INST_W  = 32,
  parameter int ADDR_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(ENTRIES)-1:0] rd_idx,
  output logic [INST_W-1:0]          rd_inst,
  input  logic                       ld_valid,
  input  logic [$clog2(NUM_WIN)-1:0] ld_win,
  input  logic [$clog2(ENTRIES)-1:0] ld_idx,
  input  logic [INST_W-1:0]          ld_data,
  input  logic                       call_valid,
  input  logic [ADDR_W-1:0]          call_target,
  input  logic [ADDR_W-1:0]          call_ret_addr,
  output logic [ADDR_W-1:0]          call_pc,
  output logic [ADDR_W-1:0]          call_link,
  input  logic                       ret_valid,
  input  logic [ADDR_W-1:0]          ret_link,
  output logic [ADDR_W-1:0]          ret_pc,
  output logic [$clog2(NUM_WIN)-1:0] active_win
);
  import irf_pkg::*;

  localparam int WPTR_W = $clog2(NUM_WIN);
  localparam logic [INST_W-1:0] NOP_W = INST_W'(IRF_NOP_WORD);

  // Named internal events
  logic [WPTR_W-1:0] cur_win;
  irf_evt_e          ptr_evt;

  irf_win_ptr #(
    .ADDR_W (ADDR_W),
    .WPTR_W (WPTR_W)
  ) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .call_valid  (call_valid),
    .call_target (call_target),
    .ret_valid   (ret_valid),
    .ret_link    (ret_link),
    .wptr        (cur_win),
    .evt         (ptr_evt)
  );

  irf_addr_xlate #(
    .ADDR_W (ADDR_W),
    .WPTR_W (WPTR_W)
  ) u_xlate (
    .wptr          (cur_win),
    .call_target   (call_target),
    .call_ret_addr (call_ret_addr),
    .ret_link      (ret_link),
    .call_pc       (call_pc),
    .call_link     (call_link),
    .ret_pc        (ret_pc)
  );

  irf_bank_store #(
    .NUM_WIN (NUM_WIN),
    .ENTRIES (ENTRIES),
    .SHARED  (SHARED),
    .INST_W  (INST_W),
    .NOP     (NOP_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (rd_idx),
    .rd_win   (cur_win),
    .rd_inst  (rd_inst),
    .ld_valid (ld_valid),
    .ld_win   (ld_win),
    .ld_idx   (ld_idx),
    .ld_data  (ld_data)
  );

  assign active_win = cur_win;

  // The event code is informative only; keep it observed
  logic evt_unused;
  assign evt_unused = ^ptr_evt;

endmodule

// File: rtl/irf_windowed_chk.sv
module irf_windowed_chk #(
  parameter int NUM_WIN = 4,
  parameter int ENTRIES = 32,
  parameter int SHARED  = 4,
  parameter int INST_W  = 32,
  parameter int ADDR_W  = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [$clog2(ENTRIES)-1:0] rd_idx,
  input logic [INST_W-1:0]          rd_inst,
  input logic                       ld_valid,
  input logic [$clog2(NUM_WIN)-1:0] ld_win,
  input logic [$clog2(ENTRIES)-1:0] ld_idx,
  input logic                       call_valid,
  input logic [ADDR_W-1:0]          call_target,
  input logic [ADDR_W-1:0]          call_link,
  input logic                       ret_valid,
  input logic [ADDR_W-1:0]          ret_link,
  input logic [$clog2(NUM_WIN)-1:0] active_win
);
  localparam int WPTR_W = $clog2(NUM_WIN);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam logic [IDX_W-1:0] SH_LIM = IDX_W'(SHARED);

  // R2
  call_sets_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_valid |=> active_win == $past(call_target[ADDR_W-1 -: WPTR_W]));

  // R3
  link_carries_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_valid |-> call_link[ADDR_W-1 -: WPTR_W] == active_win);

  // R4
  ret_restores_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !call_valid) |=> active_win == $past(ret_link[ADDR_W-1 -: WPTR_W]));

  // R10
  win_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!call_valid && !ret_valid) |=> $stable(active_win));

  // R6
  slot0_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == '0) |-> (rd_inst == '0));

  // R8
  foreign_load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_win != active_win && ld_idx >= SH_LIM && !call_valid && !ret_valid)
      |=> ($stable(rd_idx) |-> $stable(rd_inst)));

  // R7
  shared_switch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((call_valid || ret_valid) && !ld_valid && rd_idx < SH_LIM)
      |=> ($stable(rd_idx) |-> $stable(rd_inst)));

endmodule

bind irf_windowed irf_windowed_chk #(
  .NUM_WIN (NUM_WIN),
  .ENTRIES (ENTRIES),
  .SHARED  (SHARED),
  .INST_W  (INST_W),
  .ADDR_W  (ADDR_W)
) u_chk (.*);

// File: tb/irf_windowed_tb.sv
module irf_windowed_tb;
  localparam int NW = 4;
  localparam int NE = 32;
  localparam int SH = 4;

  logic        clk, rst_n;
  logic [4:0]  rd_idx;
  logic [31:0] rd_inst;
  logic        ld_valid;
  logic [1:0]  ld_win;
  logic [4:0]  ld_idx;
  logic [31:0] ld_data;
  logic        call_valid;
  logic [31:0] call_target, call_ret_addr, call_pc, call_link;
  logic        ret_valid;
  logic [31:0] ret_link, ret_pc;
  logic [1:0]  active_win;

  irf_windowed #(.NUM_WIN(NW), .ENTRIES(NE), .SHARED(SH), .INST_W(32), .ADDR_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_inst(rd_inst),
    .ld_valid(ld_valid), .ld_win(ld_win), .ld_idx(ld_idx), .ld_data(ld_data),
    .call_valid(call_valid), .call_target(call_target), .call_ret_addr(call_ret_addr),
    .call_pc(call_pc), .call_link(call_link),
    .ret_valid(ret_valid), .ret_link(ret_link), .ret_pc(ret_pc),
    .active_win(active_win)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // Reference model: shared list and per-window lists of words
  int unsigned m_sh [NE];
  int unsigned m_wb [NW][NE];
  int          m_win;
  string       win_tag;
  string       rd_tag_force;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int unsigned model_read(input int idx);
    if (idx == 0) return 0;
    if (idx < SH) return m_sh[idx];
    return m_wb[m_win][idx];
  endfunction

  task automatic compare_all();
    string t;
    if (rd_tag_force != "") t = rd_tag_force;
    else if (rd_idx == 0) t = "R6";
    else if (int'(rd_idx) < SH) t = "R7";
    else t = "R8";
    chk(t, rd_inst, model_read(int'(rd_idx)));
    chk(win_tag, {30'd0, active_win}, m_win);
    chk("R2", call_pc, {2'b00, call_target[29:0]});
    chk("R3", call_link, {m_win[1:0], call_ret_addr[29:0]});
    chk("R4", ret_pc, {2'b00, ret_link[29:0]});
  endtask

  // Compare before the edge, then advance the model with the same inputs
  task automatic tick();
    #4;
    compare_all();
    @(posedge clk);
    if (call_valid) begin
      m_win = int'(call_target[31:30]);
      win_tag = ret_valid ? "R5" : "R2";
    end else if (ret_valid) begin
      m_win = int'(ret_link[31:30]);
      win_tag = "R4";
    end else begin
      win_tag = "R10";
    end
    if (ld_valid && ld_idx != 0) begin
      if (int'(ld_idx) < SH) m_sh[ld_idx] = ld_data;
      else m_wb[ld_win][ld_idx] = ld_data;
    end
    @(negedge clk);
    rd_tag_force = "";
  endtask

  task automatic idle();
    ld_valid = 0; call_valid = 0; ret_valid = 0;
  endtask

  initial begin
    rst_n = 0; rd_idx = 0; ld_win = 0; ld_idx = 0; ld_data = 0;
    call_target = 0; call_ret_addr = 0; ret_link = 0;
    idle();
    m_win = 0; win_tag = "R1"; rd_tag_force = "";
    for (int i = 0; i < NE; i++) begin
      m_sh[i] = 0;
      for (int w = 0; w < NW; w++) m_wb[w][i] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: reads under reset, window 0
    for (int i = 0; i < NE; i++) begin
      rd_idx = 5'(i);
      #1;
      chk("R1", rd_inst, 32'd0);
      chk("R1", {30'd0, active_win}, 32'd0);
    end
    @(negedge clk);
    rst_n = 1;
    rd_idx = 5;
    rd_tag_force = "R1";
    tick();

    // R7/R9: shared load through window 3 seen in window 0 next cycle
    ld_valid = 1; ld_win = 3; ld_idx = 2; ld_data = 32'hAAAA_0002; rd_idx = 2;
    tick();
    idle(); rd_tag_force = "R9";
    tick();

    // R8: loads to windows 1 and 2 leave window 0 untouched
    ld_valid = 1; ld_win = 1; ld_idx = 10; ld_data = 32'hB1B1_000A; rd_idx = 10;
    tick();
    ld_win = 2; ld_data = 32'hC2C2_000A;
    tick();
    idle();
    tick();

    // R2/R3: call into window 1
    call_valid = 1; call_target = {2'b01, 30'h0000_0100}; call_ret_addr = 32'h0000_0044;
    tick();
    idle(); rd_tag_force = "R9";
    tick();

    // R3: call into window 2, link records window 1
    call_valid = 1; call_target = {2'b10, 30'h0000_0200}; call_ret_addr = 32'hC000_0088;
    tick();
    idle();
    tick();

    // R4: return to window 3, not the stack predecessor
    ret_valid = 1; ret_link = {2'b11, 30'h0000_0300};
    tick();
    idle();
    tick();

    // R6: load to slot 0 is dropped
    ld_valid = 1; ld_win = 3; ld_idx = 0; ld_data = 32'hDEAD_BEEF; rd_idx = 0;
    tick();
    idle();
    tick();

    // R5: call and return together, call wins
    call_valid = 1; call_target = {2'b00, 30'h0000_0400};
    ret_valid = 1; ret_link = {2'b10, 30'h0000_0500};
    tick();
    idle();
    tick();

    // Random traffic
    for (int c = 0; c < 5000; c++) begin
      int r;
      r = int'($urandom_range(0, 99));
      ld_valid = ($urandom_range(0, 3) != 0);
      ld_win = 2'($urandom);
      ld_idx = 5'($urandom);
      ld_data = $urandom;
      rd_idx = 5'($urandom);
      call_valid = (r < 12);
      ret_valid = (r >= 8 && r < 20);
      call_target = $urandom;
      call_ret_addr = $urandom;
      ret_link = $urandom;
      tick();
    end
    idle();
    tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule